// File: doc/BRIEF.md
# ADC Sample Sequencer FIFO Back End

This block is the digital back end of an analog-to-digital converter with four sample sequencers. Each sequencer owns a sixteen-entry sample FIFO. A single-cycle timer trigger pulse pushes one sample into every sequencer that is switched on and whose event-select field holds the timer code. In the same cycle, the pushes into the different FIFOs happen side by side. Software drains each FIFO by reading a pop address. It watches each FIFO through one packed status word that carries the read pointer, the write pointer, the empty flag and the full flag.

Each push sets that sequencer's raw interrupt bit. Interrupt line n is high while raw bit n and mask bit n are both set. Writing ones to the status-clear address clears raw bits. The samples normally come from a 10-bit input bus. A test mode replaces them with values from a linear congruential noise generator, so software that uses the converter as an entropy source sees varied data.

The analog conversion, step sequencing and the processor-started sample path are not part of this block.

Top module: `adc_seq_fifos`

## Requirements
- R1: After reset every FIFO status word reads 0x100 (empty, both pointers 0). All interrupt lines are low. The registers at 0x00, 0x04, 0x08, 0x14 and 0x30 read 0.
- R2: The status word of sequencer n is read at 0x4C + 0x20·n. It holds the read pointer in bits 3:0, the write pointer in bits 7:4, the empty flag in bit 8 and the full flag in bit 12. All other bits are 0.
- R3: On a trigger cycle, sequencer n receives a sample only if two conditions hold: bit n of the enable register (0x00) is set, and its event-select nibble (register 0x14, bits 4n+3:4n) equals 5. Other codes are recognised but start nothing: 0 processor, 1 comparator, 4 external, 6 to 8 PWM.
- R4: After sixteen pushes a FIFO reports full, with the write pointer wrapped to equal the read pointer. A further push is dropped and leaves both the status word and the stored data unchanged.
- R5: A read of 0x48 + 0x20·n pops the oldest sample of sequencer n, zero-extended. When the read pointer reaches the write pointer, empty is set. A pop from an empty FIFO returns 0 and leaves the pointers unchanged.
- R6: A push into sequencer n sets raw interrupt bit n, which reads at 0x04 bits 3:0. Writing 1 to bit n at 0x0C clears it. If a set and a clear fall in the same cycle, the set wins.
- R7: Interrupt line n equals raw bit n AND mask bit n. The mask is register 0x08, bits 3:0. A read of 0x0C returns raw AND mask.
- R8: With test mode clear (register 0x30 bit 0), a pushed sample equals the input bus. With test mode set, a 32-bit state is advanced for each sampled sequencer in ascending sequencer order as state = state·314159 + 1, and the sample is 0x200 + bits 18:16 of the new state. The state starts at 0.
- R9: The per-sequencer input-mux register (0x40 + 0x20·n) keeps only the bits of 0x33333333. The per-sequencer control register (0x44 + 0x20·n) keeps all 32 bits. The enable register keeps 4 bits, the event-select register 16 bits and the test-mode register 1 bit.
- R10: Pushes into several sequencers in one trigger cycle all take place, each into its own FIFO, in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Register write strobe |
| busRdEn | input | 1 | Register read strobe (a read of a pop address pops) |
| busAddr | input | 8 | Register byte address |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data, combinational from address |
| trigIn | input | 1 | Timer trigger, one pulse per sample event |
| sampleIn | input | 10 | Converted sample value |
| irqOut | output | 4 | Per-sequencer interrupt lines |

## Verification
The trigger decode is swept over all sixteen event codes crossed with all sixteen enable masks. For each combination the bench predicts which write pointers advance, which separates the timer code from every other code and each enable bit from its neighbours. Mixed event-select patterns, where only some nibbles hold the timer code, show that the pushes land in the correct FIFOs in parallel. Filling one FIFO past sixteen entries shows the wrap-to-full and the dropped push. Draining the FIFOs past empty exercises the pop order and the zero return. Noise-mode runs with all sequencers enabled and then with a sparse set show that the generator advances once per sampled sequencer, in ascending order.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int NUM_SEQ = 4;
  localparam int SEQ_IDX_W = $clog2(NUM_SEQ);
  localparam int PTR_W = 4;
  localparam int FIFO_DEPTH = 1 << PTR_W;
  localparam int SAMPLE_W = 10;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int EVT_W = 4;
  localparam int EVSEL_W = NUM_SEQ * EVT_W;

  // trigger-source codes held in the event-select nibbles
  typedef enum logic [EVT_W-1:0] {
    EVT_PROC  = 4'd0,
    EVT_COMP  = 4'd1,
    EVT_EXT   = 4'd4,
    EVT_TIMER = 4'd5,
    EVT_PWM_A = 4'd6,
    EVT_PWM_B = 4'd7,
    EVT_PWM_C = 4'd8
  } evtSrcE;

  // global register addresses
  localparam logic [ADDR_W-1:0] REG_ENABLE = 8'h00;
  localparam logic [ADDR_W-1:0] REG_RAW    = 8'h04;
  localparam logic [ADDR_W-1:0] REG_MASK   = 8'h08;
  localparam logic [ADDR_W-1:0] REG_MSTAT  = 8'h0C;
  localparam logic [ADDR_W-1:0] REG_EVSEL  = 8'h14;
  localparam logic [ADDR_W-1:0] REG_TEST   = 8'h30;

  // per-sequencer window
  localparam logic [ADDR_W-1:0] WIN_BASE = 8'h40;
  localparam logic [ADDR_W-1:0] WIN_END  = 8'hC0;
  localparam int WIN_STRIDE_LOG2 = 5;
  localparam logic [WIN_STRIDE_LOG2-1:0] OFF_MUX  = 5'h00;
  localparam logic [WIN_STRIDE_LOG2-1:0] OFF_CTL  = 5'h04;
  localparam logic [WIN_STRIDE_LOG2-1:0] OFF_POP  = 5'h08;
  localparam logic [WIN_STRIDE_LOG2-1:0] OFF_STAT = 5'h0C;

  localparam logic [DATA_W-1:0] MUX_KEEP = 32'h3333_3333;

  // packed status word layout
  localparam int STAT_EMPTY_BIT = 8;
  localparam int STAT_FULL_BIT  = 12;

  // noise generator
  localparam logic [DATA_W-1:0] NOISE_MUL  = 32'd314159;
  localparam logic [SAMPLE_W-1:0] NOISE_BASE = 10'h200;

  // control-to-datapath strobes
  typedef struct packed {
    logic [NUM_SEQ-1:0]               push;
    logic [NUM_SEQ-1:0]               pop;
    logic [NUM_SEQ-1:0][SAMPLE_W-1:0] sample;
  } seqStrobeT;
endpackage

// File: rtl/adc_seq_fifo.sv
module adc_seq_fifo
  import adc_seq_pkg::*;
#(
  parameter int PTR_BITS = PTR_W,
  parameter int WORD_W = SAMPLE_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                push,
  input  logic                pop,
  input  logic [WORD_W-1:0]   pushData,
  output logic [WORD_W-1:0]   popData,
  output logic [PTR_BITS-1:0] headPtr,
  output logic [PTR_BITS-1:0] tailPtr,
  output logic                isEmpty,
  output logic                isFull
);
  localparam int DEPTH_L = 1 << PTR_BITS;

  logic [WORD_W-1:0] mem [DEPTH_L];
  logic doPush, doPop;

  assign doPush = push && !isFull;
  assign doPop  = pop && !isEmpty;
  assign popData = isEmpty ? '0 : mem[tailPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[headPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      headPtr <= '0;
      tailPtr <= '0;
      isEmpty <= 1'b1;
      isFull  <= 1'b0;
    end else begin
      if (doPush) headPtr <= PTR_BITS'(headPtr + 1'b1);
      if (doPop)  tailPtr <= PTR_BITS'(tailPtr + 1'b1);
      if (doPush && !doPop) begin
        isEmpty <= 1'b0;
        isFull  <= (PTR_BITS'(headPtr + 1'b1) == tailPtr);
      end else if (doPop && !doPush) begin
        isFull  <= 1'b0;
        isEmpty <= (PTR_BITS'(tailPtr + 1'b1) == headPtr);
      end
    end
  end

  // R2: a FIFO is never reported empty and full at once
  assert_flags_exclusive_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(isEmpty && isFull));

  // R4: a push into a full FIFO leaves the write pointer where it was
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rstN)
    (isFull && push && !pop) |=> (headPtr == $past(headPtr)) && isFull);

  // R5: a pop from an empty FIFO leaves the read pointer where it was
  assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rstN)
    (isEmpty && pop && !push) |=> (tailPtr == $past(tailPtr)) && isEmpty);
endmodule

// File: rtl/adc_seq_datapath.sv
module adc_seq_datapath
  import adc_seq_pkg::*;
(
  input  logic                              clk,
  input  logic                              rstN,
  input  seqStrobeT                         strobes,
  output logic [NUM_SEQ-1:0][DATA_W-1:0]    statusWord,
  output logic [NUM_SEQ-1:0][SAMPLE_W-1:0]  popData
);
  localparam int PAD_W = DATA_W - STAT_FULL_BIT - 1;
  localparam int GAP_W = STAT_FULL_BIT - STAT_EMPTY_BIT - 1;

  for (genvar n = 0; n < NUM_SEQ; n++) begin : gSeq
    logic [PTR_W-1:0] headPtr, tailPtr;
    logic isEmpty, isFull;

    adc_seq_fifo #(.PTR_BITS(PTR_W), .WORD_W(SAMPLE_W)) u_fifo (
      .clk      (clk),
      .rstN     (rstN),
      .push     (strobes.push[n]),
      .pop      (strobes.pop[n]),
      .pushData (strobes.sample[n]),
      .popData  (popData[n]),
      .headPtr  (headPtr),
      .tailPtr  (tailPtr),
      .isEmpty  (isEmpty),
      .isFull   (isFull)
    );

    assign statusWord[n] = {{PAD_W{1'b0}}, isFull, {GAP_W{1'b0}}, isEmpty, headPtr, tailPtr};
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
(
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             busWrEn,
  input  logic                             busRdEn,
  input  logic [ADDR_W-1:0]                busAddr,
  input  logic [DATA_W-1:0]                busWrData,
  output logic [DATA_W-1:0]                busRdData,
  input  logic                             trigIn,
  input  logic [SAMPLE_W-1:0]              sampleIn,
  input  logic [NUM_SEQ-1:0][DATA_W-1:0]   statusWord,
  input  logic [NUM_SEQ-1:0][SAMPLE_W-1:0] popData,
  output seqStrobeT                        strobes,
  output logic [NUM_SEQ-1:0]               irqOut
);
  logic [NUM_SEQ-1:0]              enableQ, maskQ, rawQ;
  logic [EVSEL_W-1:0]              evSelQ;
  logic                            testModeQ;
  logic [DATA_W-1:0]               noiseQ, noiseNext;
  logic [NUM_SEQ-1:0][DATA_W-1:0]  muxQ, ctlQ;

  logic                            inWin;
  logic [ADDR_W-1:0]               winOff;
  logic [SEQ_IDX_W-1:0]            seqIdx;
  logic [WIN_STRIDE_LOG2-1:0]      seqOff;
  logic [NUM_SEQ-1:0]              hit, clrBits;
  logic                            wrGlobal;

  // address decode
  assign inWin  = (busAddr >= WIN_BASE) && (busAddr < WIN_END);
  assign winOff = busAddr - WIN_BASE;
  assign seqIdx = SEQ_IDX_W'(winOff >> WIN_STRIDE_LOG2);
  assign seqOff = busAddr[WIN_STRIDE_LOG2-1:0];
  assign wrGlobal = busWrEn && !inWin;

  // trigger decode: enabled and programmed for the timer source
  for (genvar n = 0; n < NUM_SEQ; n++) begin : gHit
    assign hit[n] = trigIn && enableQ[n] && (evSelQ[n*EVT_W +: EVT_W] == EVT_TIMER);
    assign strobes.pop[n] = busRdEn && inWin && (seqIdx == SEQ_IDX_W'(n)) && (seqOff == OFF_POP);
  end
  assign strobes.push = hit;

  // sample source, noise chain advanced once per sampled sequencer
  always_comb begin
    noiseNext = noiseQ;
    for (int n = 0; n < NUM_SEQ; n++) begin
      strobes.sample[n] = sampleIn;
      if (testModeQ && hit[n]) begin
        noiseNext = noiseNext * NOISE_MUL + 32'd1;
        strobes.sample[n] = NOISE_BASE + SAMPLE_W'(noiseNext[18:16]);
      end
    end
  end

  assign clrBits = (wrGlobal && busAddr == REG_MSTAT) ? busWrData[NUM_SEQ-1:0] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableQ   <= '0;
      maskQ     <= '0;
      rawQ      <= '0;
      evSelQ    <= '0;
      testModeQ <= 1'b0;
      noiseQ    <= '0;
      muxQ      <= '0;
      ctlQ      <= '0;
    end else begin
      noiseQ <= noiseNext;
      rawQ   <= (rawQ & ~clrBits) | hit;
      if (wrGlobal) begin
        unique case (busAddr)
          REG_ENABLE: enableQ   <= busWrData[NUM_SEQ-1:0];
          REG_MASK:   maskQ     <= busWrData[NUM_SEQ-1:0];
          REG_EVSEL:  evSelQ    <= busWrData[EVSEL_W-1:0];
          REG_TEST:   testModeQ <= busWrData[0];
          default: ;
        endcase
      end
      if (busWrEn && inWin) begin
        if (seqOff == OFF_MUX) muxQ[seqIdx] <= busWrData & MUX_KEEP;
        if (seqOff == OFF_CTL) ctlQ[seqIdx] <= busWrData;
      end
    end
  end

  assign irqOut = rawQ & maskQ;

  // read mux
  always_comb begin
    busRdData = '0;
    if (inWin) begin
      unique case (seqOff)
        OFF_MUX:  busRdData = muxQ[seqIdx];
        OFF_CTL:  busRdData = ctlQ[seqIdx];
        OFF_POP:  busRdData = DATA_W'(popData[seqIdx]);
        OFF_STAT: busRdData = statusWord[seqIdx];
        default:  busRdData = '0;
      endcase
    end else begin
      unique case (busAddr)
        REG_ENABLE: busRdData = DATA_W'(enableQ);
        REG_RAW:    busRdData = DATA_W'(rawQ);
        REG_MASK:   busRdData = DATA_W'(maskQ);
        REG_MSTAT:  busRdData = DATA_W'(rawQ & maskQ);
        REG_EVSEL:  busRdData = DATA_W'(evSelQ);
        REG_TEST:   busRdData = DATA_W'(testModeQ);
        default:    busRdData = '0;
      endcase
    end
  end

  // R3: no sample is pushed outside a trigger cycle
  assert_push_needs_trigger_R3: assert property (@(posedge clk) disable iff (!rstN)
    !trigIn |-> (strobes.push == '0));

  // R6: every push leaves its raw interrupt bit set on the next cycle
  assert_push_sets_raw_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.push != '0) |=> ((rawQ & $past(strobes.push)) == $past(strobes.push)));

  // R8: test-mode samples stay inside the noise range
  for (genvar n = 0; n < NUM_SEQ; n++) begin : gNoiseChk
    assert_noise_range_R8: assert property (@(posedge clk) disable iff (!rstN)
      (testModeQ && strobes.push[n]) |-> (strobes.sample[n][SAMPLE_W-1:3] == NOISE_BASE[SAMPLE_W-1:3]));
  end

  // R7: an interrupt line only rises when a raw bit was set or the mask was opened
  assert_irq_cause_R7: assert property (@(posedge clk) disable iff (!rstN)
    ((irqOut & ~$past(irqOut)) != '0) |-> ($past(strobes.push != '0) || $past(wrGlobal && busAddr == REG_MASK)));
endmodule

// File: rtl/adc_seq_fifos.sv
module adc_seq_fifos
  import adc_seq_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                busWrEn,
  input  logic                busRdEn,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [DATA_W-1:0]   busWrData,
  output logic [DATA_W-1:0]   busRdData,
  input  logic                trigIn,
  input  logic [SAMPLE_W-1:0] sampleIn,
  output logic [NUM_SEQ-1:0]  irqOut
);
  seqStrobeT strobes;
  logic [NUM_SEQ-1:0][DATA_W-1:0]   statusWord;
  logic [NUM_SEQ-1:0][SAMPLE_W-1:0] popData;

  adc_seq_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .busWrEn    (busWrEn),
    .busRdEn    (busRdEn),
    .busAddr    (busAddr),
    .busWrData  (busWrData),
    .busRdData  (busRdData),
    .trigIn     (trigIn),
    .sampleIn   (sampleIn),
    .statusWord (statusWord),
    .popData    (popData),
    .strobes    (strobes),
    .irqOut     (irqOut)
  );

  adc_seq_datapath u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .statusWord (statusWord),
    .popData    (popData)
  );
endmodule

// File: tb/adc_seq_fifos_bench.sv
module adc_seq_fifos_bench;
  localparam int CLK_PERIOD = 10;

  logic clk, rstN, busWrEn, busRdEn, trigIn;
  logic [7:0] busAddr;
  logic [31:0] busWrData;
  logic [9:0] sampleIn;
  logic [31:0] busRdData;
  logic [3:0] irqOut;

  adc_seq_fifos u_adc_seq_fifos (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .trigIn(trigIn), .sampleIn(sampleIn), .irqOut(irqOut)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;

  // bench model
  logic [9:0] mData [4][16];
  int mHead [4];
  int mTail [4];
  int mCnt [4];
  logic [31:0] mNoise;
  logic [3:0] mRaw, mMask, tEnable;
  logic [15:0] tEvsel;
  logic tNoise;

  task automatic checkEq(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] expStatus(input int n);
    logic [31:0] s;
    s = 32'(mTail[n]) | (32'(mHead[n]) << 4);
    if (mCnt[n] == 0) s[8] = 1'b1;
    if (mCnt[n] == 16) s[12] = 1'b1;
    return s;
  endfunction

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busRdEn = 1'b1; busAddr = a;
    #1 d = busRdData;
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  task automatic setCfg(input logic [3:0] en, input logic [15:0] ev);
    busWrite(8'h00, 32'(en)); tEnable = en;
    busWrite(8'h14, 32'(ev)); tEvsel = ev;
  endtask

  task automatic modelPush(input int n, input logic [9:0] v);
    if (mCnt[n] < 16) begin
      mData[n][mHead[n]] = v;
      mHead[n] = (mHead[n] + 1) % 16;
      mCnt[n]++;
    end
  endtask

  // one trigger pulse, optionally with a raw-clear write in the same cycle
  task automatic pulseTrigger(input bit withClr, input logic [3:0] clr);
    logic [9:0] v;
    @(negedge clk);
    trigIn = 1'b1;
    if (withClr) begin busWrEn = 1'b1; busAddr = 8'h0C; busWrData = 32'(clr); end
    @(negedge clk);
    trigIn = 1'b0; busWrEn = 1'b0;
    if (withClr) mRaw = mRaw & ~clr;
    for (int n = 0; n < 4; n++) begin
      if (tEnable[n] && tEvsel[n*4 +: 4] == 4'd5) begin
        if (tNoise) begin
          mNoise = mNoise * 32'd314159 + 32'd1;
          v = 10'h200 + 10'(mNoise[18:16]);
        end else v = sampleIn;
        modelPush(n, v);
        mRaw[n] = 1'b1;
      end
    end
  endtask

  task automatic checkAllStatus(input string req);
    logic [31:0] d;
    for (int n = 0; n < 4; n++) begin
      busRead(8'(8'h4C + 32*n), d);
      checkEq(req, $sformatf("status seq%0d", n), d, expStatus(n));
    end
  endtask

  task automatic drain(input int n, input string req);
    logic [31:0] d;
    while (mCnt[n] > 0) begin
      busRead(8'(8'h48 + 32*n), d);
      checkEq(req, $sformatf("pop seq%0d", n), d, 32'(mData[n][mTail[n]]));
      mTail[n] = (mTail[n] + 1) % 16;
      mCnt[n]--;
    end
    busRead(8'(8'h4C + 32*n), d);
    checkEq("R5", $sformatf("empty status seq%0d", n), d, expStatus(n));
    busRead(8'(8'h48 + 32*n), d);
    checkEq("R5", $sformatf("pop empty seq%0d", n), d, 32'h0);
    busRead(8'(8'h4C + 32*n), d);
    checkEq("R5", $sformatf("status after empty pop seq%0d", n), d, expStatus(n));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    rstN = 1'b0; busWrEn = 1'b0; busRdEn = 1'b0; trigIn = 1'b0;
    busAddr = '0; busWrData = '0; sampleIn = '0;
    for (int n = 0; n < 4; n++) begin mHead[n] = 0; mTail[n] = 0; mCnt[n] = 0; end
    mNoise = '0; mRaw = '0; mMask = '0; tEnable = '0; tEvsel = '0; tNoise = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    checkEq("R1", "irq after reset", 32'(irqOut), 32'h0);
    checkAllStatus("R1");
    busRead(8'h00, d); checkEq("R1", "enable reg", d, 32'h0);
    busRead(8'h04, d); checkEq("R1", "raw reg", d, 32'h0);
    busRead(8'h08, d); checkEq("R1", "mask reg", d, 32'h0);
    busRead(8'h14, d); checkEq("R1", "evsel reg", d, 32'h0);
    busRead(8'h30, d); checkEq("R1", "test reg", d, 32'h0);

    // R9 register widths and masks
    busWrite(8'h00, 32'hFFFF_FFFF); busRead(8'h00, d); checkEq("R9", "enable keeps 4 bits", d, 32'hF);
    busWrite(8'h00, 32'h0);
    for (int n = 0; n < 4; n++) begin
      busWrite(8'(8'h40 + 32*n), 32'hFFFF_FFFF);
      busRead(8'(8'h40 + 32*n), d); checkEq("R9", "mux mask", d, 32'h3333_3333);
      busWrite(8'(8'h44 + 32*n), 32'hA5A5_0000 + 32'(n));
      busRead(8'(8'h44 + 32*n), d); checkEq("R9", "ctl readback", d, 32'hA5A5_0000 + 32'(n));
    end
    busWrite(8'h14, 32'hFFFF_FFFF); busRead(8'h14, d); checkEq("R9", "evsel keeps 16 bits", d, 32'h0000_FFFF);
    busWrite(8'h30, 32'hFFFF_FFFF); busRead(8'h30, d); checkEq("R9", "test keeps 1 bit", d, 32'h1);
    busWrite(8'h30, 32'h0);
    checkAllStatus("R9");

    // R3 sweep of every event code against every enable mask
    for (int code = 0; code < 16; code++) begin
      for (int en = 0; en < 16; en++) begin
        setCfg(4'(en), {4{4'(code)}});
        sampleIn = 10'((code * 16 + en) * 7);
        pulseTrigger(1'b0, 4'h0);
        checkAllStatus("R3");
      end
    end

    // R10 mixed event-select patterns, parallel pushes
    setCfg(4'hF, 16'h0505); sampleIn = 10'h155; pulseTrigger(1'b0, 4'h0); checkAllStatus("R10");
    setCfg(4'hF, 16'h5005); sampleIn = 10'h2AA; pulseTrigger(1'b0, 4'h0); checkAllStatus("R10");
    setCfg(4'hF, 16'h5558); sampleIn = 10'h0F0; pulseTrigger(1'b0, 4'h0); checkAllStatus("R10");

    // R5 drain everything in order
    for (int n = 0; n < 4; n++) drain(n, "R5");

    // R4 fill seq0 to full, then overflow
    setCfg(4'h1, 16'h0005);
    for (int i = 0; i < 16; i++) begin sampleIn = 10'(i * 37 + 3); pulseTrigger(1'b0, 4'h0); end
    busRead(8'h4C, d); checkEq("R4", "full status", d, expStatus(0));
    checkEq("R4", "full flag", 32'(d[12]), 32'h1);
    sampleIn = 10'h3FF; pulseTrigger(1'b0, 4'h0);
    busRead(8'h4C, d); checkEq("R4", "status after dropped push", d, expStatus(0));
    drain(0, "R4");

    // R6 / R7 raw bits, mask, irq, clear
    busWrite(8'h0C, 32'hF); mRaw = '0;
    busWrite(8'h08, 32'h5); mMask = 4'h5;
    setCfg(4'hF, 16'h5555); sampleIn = 10'h011; pulseTrigger(1'b0, 4'h0);
    busRead(8'h04, d); checkEq("R6", "raw after push", d, 32'(mRaw));
    checkEq("R7", "irq masked", 32'(irqOut), 32'(mRaw & mMask));
    busRead(8'h0C, d); checkEq("R7", "masked status", d, 32'(mRaw & mMask));
    busWrite(8'h0C, 32'h1); mRaw[0] = 1'b0;
    busRead(8'h04, d); checkEq("R6", "raw after clear", d, 32'(mRaw));
    checkEq("R7", "irq after clear", 32'(irqOut), 32'(mRaw & mMask));
    setCfg(4'h2, 16'h5555); sampleIn = 10'h022; pulseTrigger(1'b1, 4'h2);
    busRead(8'h04, d); checkEq("R6", "set wins over clear", d, 32'(mRaw));
    busWrite(8'h08, 32'hF); mMask = 4'hF;
    checkEq("R7", "irq full mask", 32'(irqOut), 32'(mRaw));
    busWrite(8'h0C, 32'hF); mRaw = '0;
    checkEq("R7", "irq all cleared", 32'(irqOut), 32'h0);
    for (int n = 0; n < 4; n++) drain(n, "R6");

    // R8 noise model, dense then sparse
    busWrite(8'h30, 32'h1); tNoise = 1'b1;
    setCfg(4'hF, 16'h5555);
    for (int i = 0; i < 3; i++) pulseTrigger(1'b0, 4'h0);
    setCfg(4'hA, 16'h5555);
    for (int i = 0; i < 2; i++) pulseTrigger(1'b0, 4'h0);
    checkAllStatus("R8");
    for (int n = 0; n < 4; n++) drain(n, "R8");
    busWrite(8'h30, 32'h0); tNoise = 1'b0;
    sampleIn = 10'h1C3; pulseTrigger(1'b0, 4'h0);
    for (int n = 0; n < 4; n++) drain(n, "R8");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule